// File: doc/BRIEF.md
# Branch-trace nibble address receiver

This block receives a debug trace stream that is four bits wide and reports the destination address of each taken branch. On every rising edge of the trace clock it samples a 4-bit data bus and a sync line. A cycle with sync high carries a command nibble. The command says how many address nibbles follow in the cycles with sync low: 1, 2, 4 or 8. Those nibbles arrive least significant first. They overwrite only the low-order part of the previous destination, and the upper part keeps its old value.

A transfer is finished only when the next sync-high cycle arrives. In that cycle the block publishes the assembled 32-bit address and raises a one-cycle valid strobe. It also reports which length was used. The same sync-high cycle is decoded as the next command, so transfers can follow each other with no gap. A transfer that is cut short produces nothing. The trace clock is the block's only clock.

Top module: `trace_addr_rx`

## Requirements
- R1: The data nibble is formed with dataIn[3] as its most significant bit. The first address nibble after a command goes to addrOut[3:0]. Each following nibble goes to the next higher 4-bit position.
- R2: With syncIn high, command 0x8 selects 1 address nibble and lenCode 0. Command 0x9 selects 2 nibbles and lenCode 1. Command 0xA selects 4 nibbles and lenCode 2. Command 0xB selects 8 nibbles and lenCode 3.
- R3: Once all selected nibbles have been received, the next rising edge with syncIn high updates addrOut. The same edge raises addrValid for exactly one cycle. addrOut changes at no other time.
- R4: Address nibbles above the selected length keep the values of the last completed address.
- R5: If syncIn goes high before all selected nibbles have arrived, there is no addrValid pulse and addrOut is unchanged. The next transfer builds on the last completed address, not on the partial one.
- R6: Nibbles received with syncIn low after the selected count has been reached are ignored. They change no address bit.
- R7: Any other command value, including the idle value 0x3, selects no transfer. Nibbles that follow it are ignored, and the next sync-high cycle raises no addrValid.
- R8: After reset, addrOut is 0, addrValid is 0 and lenCode is 0. No transfer is selected, so nibbles with syncIn low that come before the first command are ignored.
- R9: A sync-high cycle that completes a transfer is also decoded as a new command. The next transfer can therefore start in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Trace clock; all sampling is on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| syncIn | input | 1 | High marks a command cycle, low marks an address-nibble cycle |
| dataIn | input | 4 | Trace data nibble, bit 3 most significant |
| addrOut | output | 32 | Last completed destination address |
| addrValid | output | 1 | One-cycle strobe marking a newly completed address |
| lenCode | output | 2 | Length code of the last completed transfer (0:1, 1:2, 2:4, 3:8 nibbles) |

## Verification
The assertions assume that syncIn and dataIn are stable around each rising edge of the trace clock. They also assume the bus stays in the idle command state whenever no transfer is wanted. The checks on upper nibbles rely on addrOut changing only when addrValid is high.

The stimulus changes inputs only on falling edges. It keeps to command values that are legal, undefined or idle. Between transfers it always returns to the idle command, and it never leaves syncIn undriven.

// File: rtl/trace_addr_rx_pkg.sv
`timescale 1ns/1ps
package trace_addr_rx_pkg;
  localparam int NIB_W    = 4;                       // bits per trace nibble
  localparam int LEN_W    = 2;                       // width of the length code
  localparam int ADDR_NIB = 1 << ((1 << LEN_W) - 1); // longest transfer in nibbles
  localparam int ADDR_W   = NIB_W * ADDR_NIB;        // address width
  localparam int IDX_W    = $clog2(ADDR_NIB);        // nibble lane index width
  localparam int CNT_W    = $clog2(ADDR_NIB + 1);    // received nibble count width
  localparam logic [NIB_W-1:0] CMD_MASK = 4'b1100;   // command family bits
  localparam logic [NIB_W-1:0] CMD_BASE = 4'b1000;   // branch-destination family

  typedef struct packed {
    logic             reload;  // sync-high cycle: restart from last address
    logic             commit;  // complete transfer is being published
    logic             write;   // store dataIn into lane idx
    logic [IDX_W-1:0] idx;     // lane being written
    logic [LEN_W-1:0] code;    // length code of the transfer in progress
  } rx_strobe_t;
endpackage

// File: rtl/trace_addr_rx_ctrl.sv
`timescale 1ns/1ps
module trace_addr_rx_ctrl
  import trace_addr_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             syncIn,
  input  logic [NIB_W-1:0] dataIn,
  output rx_strobe_t       strobes,
  output logic [CNT_W-1:0] nibCnt
);
  logic             active;
  logic [LEN_W-1:0] curCode;
  logic [CNT_W-1:0] expCnt;
  logic             isCmd;
  logic             gotAll;

  assign expCnt = CNT_W'(1) << curCode;
  assign isCmd  = (dataIn & CMD_MASK) == CMD_BASE;
  assign gotAll = active && (nibCnt == expCnt);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active  <= 1'b0;
      curCode <= '0;
      nibCnt  <= '0;
    end else if (syncIn) begin
      active  <= isCmd;
      curCode <= dataIn[LEN_W-1:0];
      nibCnt  <= '0;
    end else if (strobes.write) begin
      nibCnt  <= nibCnt + CNT_W'(1);
    end
  end

  always_comb begin
    strobes.reload = syncIn;
    strobes.commit = syncIn && gotAll;
    strobes.write  = !syncIn && active && (nibCnt < expCnt);
    strobes.idx    = nibCnt[IDX_W-1:0];
    strobes.code   = curCode;
  end
endmodule

// File: rtl/trace_addr_rx_dp.sv
`timescale 1ns/1ps
module trace_addr_rx_dp
  import trace_addr_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NIB_W-1:0]  dataIn,
  input  rx_strobe_t        strobes,
  output logic [ADDR_W-1:0] lastAddr,
  output logic              validQ,
  output logic [LEN_W-1:0]  lenQ
);
  logic [ADDR_W-1:0] workAddr;

  for (genvar i = 0; i < ADDR_NIB; i++) begin : g_lane
    logic [NIB_W-1:0] laneQ;
    always_ff @(posedge clk) begin
      if (!rstN)
        laneQ <= '0;
      else if (strobes.reload)
        laneQ <= strobes.commit ? laneQ : lastAddr[i*NIB_W +: NIB_W];
      else if (strobes.write && (strobes.idx == IDX_W'(i)))
        laneQ <= dataIn;
    end
    assign workAddr[i*NIB_W +: NIB_W] = laneQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastAddr <= '0;
      validQ   <= 1'b0;
      lenQ     <= '0;
    end else begin
      validQ <= strobes.commit;
      if (strobes.commit) begin
        lastAddr <= workAddr;
        lenQ     <= strobes.code;
      end
    end
  end
endmodule

// File: rtl/trace_addr_rx.sv
`timescale 1ns/1ps
module trace_addr_rx
  import trace_addr_rx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        syncIn,
  input  logic [3:0]  dataIn,
  output logic [31:0] addrOut,
  output logic        addrValid,
  output logic [1:0]  lenCode
);
  rx_strobe_t       strobes;
  logic [CNT_W-1:0] nibCnt;

  trace_addr_rx_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .syncIn(syncIn), .dataIn(dataIn),
    .strobes(strobes), .nibCnt(nibCnt)
  );

  trace_addr_rx_dp dp_i (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .strobes(strobes),
    .lastAddr(addrOut), .validQ(addrValid), .lenQ(lenCode)
  );
endmodule

// File: rtl/trace_addr_rx_chk.sv
`timescale 1ns/1ps
module trace_addr_rx_chk
  import trace_addr_rx_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              syncIn,
  input logic [ADDR_W-1:0] addrOut,
  input logic              addrValid,
  input logic [LEN_W-1:0]  lenCode,
  input logic              wrStb,
  input logic [CNT_W-1:0]  nibCnt
);
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |=> !addrValid); // R3
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !addrValid |-> $stable(addrOut)); // R3
  AST_COMMIT_ON_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    $rose(addrValid) |-> $past(syncIn)); // R3
  AST_KEEP_UPPER_1: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && lenCode == 2'd0) |-> (addrOut[ADDR_W-1:4] == $past(addrOut[ADDR_W-1:4]))); // R4
  AST_KEEP_UPPER_2: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && lenCode == 2'd1) |-> (addrOut[ADDR_W-1:8] == $past(addrOut[ADDR_W-1:8]))); // R4
  AST_KEEP_UPPER_4: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && lenCode == 2'd2) |-> (addrOut[ADDR_W-1:16] == $past(addrOut[ADDR_W-1:16]))); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    nibCnt <= CNT_W'(ADDR_NIB)); // R6
  AST_WRITE_ONLY_LOW: assert property (@(posedge clk) disable iff (!rstN)
    wrStb |-> !syncIn); // R1
  AST_COUNT_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    syncIn |=> (nibCnt == '0)); // R9
endmodule

bind trace_addr_rx trace_addr_rx_chk chk_i (
  .clk(clk), .rstN(rstN), .syncIn(syncIn), .addrOut(addrOut),
  .addrValid(addrValid), .lenCode(lenCode), .wrStb(strobes.write), .nibCnt(nibCnt)
);

// File: tb/trace_addr_rx_tb_top.sv
`timescale 1ns/1ps
module trace_addr_rx_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        syncIn = 1'b1;
  logic [3:0]  dataIn = 4'h3;
  logic [31:0] addrOut;
  logic        addrValid;
  logic [1:0]  lenCode;

  int checks = 0;
  int errors = 0;
  bit monOn = 1'b0;
  bit done = 1'b0;

  logic [31:0] qAddr[$];
  logic [1:0]  qCode[$];
  string       qTag[$];
  string       phase = "R1";

  int          mExp = 0;
  int          mCnt = 0;
  logic [1:0]  mCode = 2'd0;
  logic [31:0] mWork = '0;
  logic [31:0] mLast = '0;
  logic [31:0] prevOut = '0;
  int          cycles = 0;

  trace_addr_rx dut_i (
    .clk(clk), .rstN(rstN), .syncIn(syncIn), .dataIn(dataIn),
    .addrOut(addrOut), .addrValid(addrValid), .lenCode(lenCode)
  );

  always #4 clk = ~clk; // 8 ns period, 125 MHz

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic drive(input bit s, input logic [3:0] nib);
    @(negedge clk);
    syncIn = s;
    dataIn = nib;
    if (s) begin
      if (mExp != 0 && mCnt == mExp) begin
        qAddr.push_back(mWork);
        qCode.push_back(mCode);
        qTag.push_back(phase);
        mLast = mWork;
      end
      mCnt  = 0;
      mWork = mLast;
      mCode = nib[1:0];
      mExp  = (nib >= 4'h8 && nib <= 4'hB) ? (1 << nib[1:0]) : 0;
    end else if (mExp != 0 && mCnt < mExp) begin
      mWork[mCnt*4 +: 4] = nib;
      mCnt++;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b1, 4'h3);
  endtask

  task automatic xfer(input logic [3:0] cmd, input int n, input logic [31:0] val);
    drive(1'b1, cmd);
    for (int i = 0; i < n; i++) drive(1'b0, val[i*4 +: 4]);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (monOn && !done) begin
      if (addrValid) begin
        if (qAddr.size() == 0) begin
          check(1'b0, "R3 unexpected addrValid", addrOut, prevOut);
        end else begin
          logic [31:0] ea;
          logic [1:0]  ec;
          string       et;
          ea = qAddr.pop_front();
          ec = qCode.pop_front();
          et = qTag.pop_front();
          check(addrOut == ea, {et, " address"}, addrOut, ea);
          check(lenCode == ec, {"R2 lenCode in ", et}, 32'(lenCode), 32'(ec));
        end
      end else if (addrOut != prevOut) begin
        check(1'b0, "R3 addrOut changed without strobe", addrOut, prevOut);
      end
      prevOut = addrOut;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected below 200000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R8 reset state
    check(addrOut == 32'h0, "R8 addrOut after reset", addrOut, 32'h0);
    check(addrValid == 1'b0, "R8 addrValid after reset", 32'(addrValid), 32'h0);
    check(lenCode == 2'd0, "R8 lenCode after reset", 32'(lenCode), 32'h0);
    monOn = 1'b1;

    phase = "R8";
    drive(1'b0, 4'hF); drive(1'b0, 4'hE);
    idle(2);
    @(negedge clk);
    check(addrOut == 32'h0, "R8 nibbles before first command", addrOut, 32'h0);

    phase = "R1"; xfer(4'h8, 1, 32'h5); idle(2);
    phase = "R2"; xfer(4'h9, 2, 32'hBA);
    phase = "R9"; xfer(4'hB, 8, 32'h87654321);
    phase = "R9"; xfer(4'hA, 4, 32'hCDEF); idle(2);
    phase = "R4"; xfer(4'h9, 2, 32'h12); idle(2);

    phase = "R5";
    held = mLast;
    xfer(4'hB, 3, 32'h999); idle(2);
    @(negedge clk);
    check(addrOut == held, "R5 short transfer kept address", addrOut, held);
    xfer(4'h8, 1, 32'hF); idle(2);

    phase = "R6";
    xfer(4'h9, 2, 32'h34);
    drive(1'b0, 4'hA); drive(1'b0, 4'hB); drive(1'b0, 4'hC);
    idle(2);

    phase = "R7";
    held = mLast;
    xfer(4'hC, 2, 32'h11); xfer(4'h0, 2, 32'h22);
    xfer(4'h7, 1, 32'h3); xfer(4'h3, 2, 32'h44); xfer(4'hF, 8, 32'h55555555);
    idle(2);
    @(negedge clk);
    check(addrOut == held, "R7 undefined commands ignored", addrOut, held);

    phase = "R3";
    seed = 32'h1234ABCD;
    for (int k = 0; k < 60; k++) begin
      int n;
      logic [3:0] cmd;
      seed = seed * 32'd1664525 + 32'd1013904223;
      cmd = (seed[31:29] == 3'd0) ? 4'h6 : {2'b10, seed[28:27]};
      n = (cmd == 4'h6) ? 2 : (1 << seed[28:27]);
      if (seed[26:24] == 3'd1) n = n - 1 > 0 ? n - 1 : 0;
      if (seed[26:24] == 3'd2) n = n + 2;
      xfer(cmd, n, seed ^ 32'h5A5AA5A5);
      if (seed[23]) idle(1);
    end
    idle(3);
    repeat (2) @(negedge clk);
    check(qAddr.size() == 0, "R3 all expected strobes seen", 32'(qAddr.size()), 32'h0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule